// File: doc/BRIEF.md
# Sampled-Clock Register Emulator

This block behaves like an ordinary register with its own design clock, clock enable, synchronous reset, asynchronous load and either an asynchronous reset or a per-bit set/clear pair, yet every storage element inside it runs on a single fast global sampling clock. The design clock is treated as plain data. The block remembers its level from the previous global cycle, recognises the active transition by comparing that memory with the present level, and on that transition presents the data value captured one global cycle earlier. In every other global cycle the output is the value it held before.

Asynchronous controls reach the output combinationally in the same global cycle they appear. Each control is also remembered for one global cycle, and the remembered copy keeps the control in force for one extra cycle after release, so a pulse is never lost between samples. Parameters select the data width, the active clock transition, the asynchronous variant, the polarity of all asynchronous controls, and the initial, asynchronous-reset and synchronous-reset values.

Top module: `gcff_emul`

## Requirements
- R1: While `rst_n` is low and in the cycles after its release, `q` equals `INIT_VAL`. No transition is detected in the first cycle after release, as long as `eclk` rests at its idle level (low for rising polarity, high for falling polarity).
- R2: With `CLK_RISE` = 1, a change of `eclk` from 0 to 1 is detected in the global cycle where `eclk` is first seen high. In that same cycle `q` shows the next value computed from the inputs sampled at the preceding `gclk` rising edge.
- R3: With `CLK_RISE` = 0, the change of `eclk` from 1 to 0 is the active transition. It behaves as in R2, and a change from 0 to 1 leaves `q` unchanged.
- R4: Without an active transition and without an active asynchronous control, `q` keeps its value, whatever `d`, `ce` and `srst` do.
- R5: On an active transition with `ce` = 0 and `srst` = 0, `q` reloads its held value.
- R6: On an active transition with `srst` = 1, `q` becomes `SRST_VAL`. `srst` takes priority over `ce`.
- R7: An active `aload` drives `q` to `adata` in the same global cycle. The load stays selected for one further global cycle after `aload` is released. After that, `q` holds the last `adata` that was loaded.
- R8: In reset mode (`ASYNC_MODE` = 1), an active `arst` forces `q` to `RST_VAL` at once. It overrides both `aload` and a coincident clock transition. The force lasts one cycle beyond release, and `q` then holds `RST_VAL` until the next transition.
- R9: In set/clear mode (`ASYNC_MODE` = 2), each bit of `q` is (value OR set) AND NOT clear. A bit with both controls active reads 0.
- R10: With `CTRL_LOW` = 1, `arst`, `aload`, `aset` and `aclr` are active at level 0. While any of them rests at 1, it has no effect on `q`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| gclk | input | 1 | Global sampling clock |
| rst_n | input | 1 | Active-low reset of the sampling flops to their initial values |
| eclk | input | 1 | Emulated design clock, sampled as data |
| d | input | WIDTH | Data input |
| ce | input | 1 | Clock enable |
| srst | input | 1 | Synchronous reset, active high |
| aload | input | 1 | Asynchronous load enable |
| adata | input | WIDTH | Asynchronous load data |
| arst | input | 1 | Asynchronous reset (reset mode) |
| aset | input | WIDTH | Per-bit asynchronous set (set/clear mode) |
| aclr | input | WIDTH | Per-bit asynchronous clear (set/clear mode) |
| q | output | WIDTH | Register output |

## Verification
The clock transition and the asynchronous reset can land in the same global cycle. The bench provokes this by raising `eclk` and asserting `arst` on the same falling edge of `gclk`, while `d` holds a value that differs from the reset value. It then expects `RST_VAL` in that cycle, in the widened release cycle and after the transition has passed, so the captured data must never appear. A second collision raises set and clear on the same bit and expects a 0 there, and a third releases `aload` while `adata` changes, so the widened tail must show the new data.

// File: rtl/gcff_pkg.sv
package gcff_pkg;
   typedef enum logic [1:0] {
      AM_NONE   = 2'd0,
      AM_RESET  = 2'd1,
      AM_SETCLR = 2'd2
   } async_mode_e;
endpackage

// File: rtl/gcff_edge_det.sv
module gcff_edge_det #(
   parameter bit CLK_RISE = 1'b1
) (
   input  logic gclk,
   input  logic rst_n,
   input  logic eclk,
   output logic edge_o
);
   // level that follows the active transition: avoids a false edge at start
   localparam logic IDLE_LVL = CLK_RISE ? 1'b1 : 1'b0;

   logic clk_prev;

   always_ff @(posedge gclk or negedge rst_n) begin
      if (!rst_n) clk_prev <= IDLE_LVL;
      else        clk_prev <= eclk;
   end

   generate
      if (CLK_RISE) begin : g_rise
         assign edge_o = eclk & ~clk_prev;
      end else begin : g_fall
         assign edge_o = ~eclk & clk_prev;
      end
   endgenerate

   AST_EDGE_SPACED: assert property (@(posedge gclk) disable iff (!rst_n)
      edge_o |=> !edge_o); // R2
endmodule

// File: rtl/gcff_async_widen.sv
module gcff_async_widen #(
   parameter int W       = 1,
   parameter bit ACT_LOW = 1'b0
) (
   input  logic         gclk,
   input  logic         rst_n,
   input  logic [W-1:0] ctl_i,
   output logic [W-1:0] act_o   // normalised: 1 = control in force
);
   localparam logic [W-1:0] PAST_INIT = ACT_LOW ? {W{1'b1}} : {W{1'b0}};

   logic [W-1:0] ctl_prev;
   logic [W-1:0] raw_act;

   always_ff @(posedge gclk or negedge rst_n) begin
      if (!rst_n) ctl_prev <= PAST_INIT;
      else        ctl_prev <= ctl_i;
   end

   generate
      if (ACT_LOW) begin : g_low
         assign act_o   = ~(ctl_i & ctl_prev);
         assign raw_act = ~ctl_i;
      end else begin : g_high
         assign act_o   = ctl_i | ctl_prev;
         assign raw_act = ctl_i;
      end
   endgenerate

   AST_WIDEN_TAIL: assert property (@(posedge gclk) disable iff (!rst_n)
      (raw_act != '0) |=> ((act_o & $past(raw_act)) == $past(raw_act))); // R7
endmodule

// File: rtl/gcff_core.sv
module gcff_core #(
   parameter int              W        = 8,
   parameter logic [W-1:0]    INIT_VAL = '0
) (
   input  logic         gclk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,     // data after enable / sync reset
   input  logic         edge_i,
   input  logic [W-1:0] q_i,     // final output, fed back for hold
   output logic [W-1:0] qc_o     // clocked value before async overrides
);
   logic [W-1:0] d_prev;
   logic [W-1:0] q_prev;

   always_ff @(posedge gclk or negedge rst_n) begin
      if (!rst_n) begin
         d_prev <= INIT_VAL;
         q_prev <= INIT_VAL;
      end else begin
         d_prev <= d_i;
         q_prev <= q_i;
      end
   end

   assign qc_o = edge_i ? d_prev : q_prev;

   AST_EDGE_TAKES_D: assert property (@(posedge gclk) disable iff (!rst_n)
      ($past(rst_n) && edge_i) |-> (qc_o == $past(d_i))); // R2
   AST_HOLD_NO_EDGE: assert property (@(posedge gclk) disable iff (!rst_n)
      ($past(rst_n) && !edge_i) |-> (qc_o == $past(q_i))); // R4
endmodule

// File: rtl/gcff_emul.sv
module gcff_emul
   import gcff_pkg::*;
#(
   parameter int           WIDTH      = 8,
   parameter bit           CLK_RISE   = 1'b1,
   parameter async_mode_e  ASYNC_MODE = AM_RESET,
   parameter bit           CTRL_LOW   = 1'b0,
   parameter logic [WIDTH-1:0] INIT_VAL = '0,
   parameter logic [WIDTH-1:0] RST_VAL  = '0,
   parameter logic [WIDTH-1:0] SRST_VAL = '0
) (
   input  logic             gclk,
   input  logic             rst_n,
   input  logic             eclk,
   input  logic [WIDTH-1:0] d,
   input  logic             ce,
   input  logic             srst,
   input  logic             aload,
   input  logic [WIDTH-1:0] adata,
   input  logic             arst,
   input  logic [WIDTH-1:0] aset,
   input  logic [WIDTH-1:0] aclr,
   output logic [WIDTH-1:0] q
);
   localparam logic [WIDTH-1:0] NO_BITS = {WIDTH{1'b0}};

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("gcff_emul: WIDTH must be at least 1");
      end
      if (ASYNC_MODE != AM_NONE && ASYNC_MODE != AM_RESET && ASYNC_MODE != AM_SETCLR) begin : g_bad_mode
         $error("gcff_emul: unsupported ASYNC_MODE");
      end
   endgenerate

   logic             edge_w;
   logic             ld_act;
   logic             rst_act;
   logic [WIDTH-1:0] set_act;
   logic [WIDTH-1:0] clr_act;
   logic [WIDTH-1:0] d_eff;
   logic [WIDTH-1:0] q_clk;
   logic [WIDTH-1:0] q_ld;

   gcff_edge_det #(.CLK_RISE(CLK_RISE)) u_edge (
      .gclk(gclk), .rst_n(rst_n), .eclk(eclk), .edge_o(edge_w)
   );

   gcff_async_widen #(.W(1), .ACT_LOW(CTRL_LOW)) u_w_load (
      .gclk(gclk), .rst_n(rst_n), .ctl_i(aload), .act_o(ld_act)
   );
   gcff_async_widen #(.W(1), .ACT_LOW(CTRL_LOW)) u_w_rst (
      .gclk(gclk), .rst_n(rst_n), .ctl_i(arst), .act_o(rst_act)
   );
   gcff_async_widen #(.W(WIDTH), .ACT_LOW(CTRL_LOW)) u_w_set (
      .gclk(gclk), .rst_n(rst_n), .ctl_i(aset), .act_o(set_act)
   );
   gcff_async_widen #(.W(WIDTH), .ACT_LOW(CTRL_LOW)) u_w_clr (
      .gclk(gclk), .rst_n(rst_n), .ctl_i(aclr), .act_o(clr_act)
   );

   // enable and synchronous reset folded into the sampled data path
   always_comb begin
      if (srst)    d_eff = SRST_VAL;
      else if (ce) d_eff = d;
      else         d_eff = q;
   end

   gcff_core #(.W(WIDTH), .INIT_VAL(INIT_VAL)) u_core (
      .gclk(gclk), .rst_n(rst_n), .d_i(d_eff), .edge_i(edge_w),
      .q_i(q), .qc_o(q_clk)
   );

   always_comb begin
      q_ld = ld_act ? adata : q_clk;
      case (ASYNC_MODE)
         AM_RESET:  q = rst_act ? RST_VAL : q_ld;
         AM_SETCLR: q = (q_ld | set_act) & ~clr_act;
         default:   q = q_ld | (NO_BITS & set_act & clr_act & {WIDTH{rst_act}});
      endcase
   end

   generate
      if (ASYNC_MODE == AM_RESET) begin : g_chk_rst
         logic rst_raw;
         assign rst_raw = CTRL_LOW ? ~arst : arst;
         AST_RESET_WINS: assert property (@(posedge gclk) disable iff (!rst_n)
            rst_raw |-> (q == RST_VAL)); // R8
      end
      if (ASYNC_MODE == AM_SETCLR) begin : g_chk_sc
         logic [WIDTH-1:0] set_raw;
         logic [WIDTH-1:0] clr_raw;
         assign set_raw = CTRL_LOW ? ~aset : aset;
         assign clr_raw = CTRL_LOW ? ~aclr : aclr;
         AST_CLEAR_WINS: assert property (@(posedge gclk) disable iff (!rst_n)
            ((q & clr_raw) == '0)); // R9
         AST_SET_FORCES: assert property (@(posedge gclk) disable iff (!rst_n)
            ((q & set_raw & ~clr_raw) == (set_raw & ~clr_raw))); // R9
      end
   endgenerate
endmodule

// File: tb/gcff_emul_bench.sv
`timescale 1ns/1ps
module gcff_emul_bench;
   import gcff_pkg::*;

   localparam logic [7:0] INIT_A = 8'h5A;
   localparam logic [7:0] RST_A  = 8'hC3;
   localparam logic [7:0] SRST_A = 8'h0F;
   localparam logic [7:0] INIT_B = 8'h00;
   localparam logic [7:0] SRST_B = 8'hF0;

   typedef struct {
      logic [7:0] exp;
      bit         sel_b;
      string      tag;
   } sb_item_t;

   logic       gclk = 1'b0;
   logic       rst_n = 1'b0;
   logic       eclk_a = 1'b0;
   logic       eclk_b = 1'b1;
   logic [7:0] d = 8'h00;
   logic       ce = 1'b1;
   logic       srst = 1'b0;
   logic [7:0] adata = 8'h00;
   logic       a_aload = 1'b0;
   logic       a_arst = 1'b0;
   logic       b_aload_n = 1'b1;
   logic [7:0] b_aset_n = 8'hFF;
   logic [7:0] b_aclr_n = 8'hFF;
   logic [7:0] q_a;
   logic [7:0] q_b;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   logic [7:0] m_a = INIT_A;
   logic [7:0] m_b = INIT_B;
   sb_item_t sb[$];

   always #2 gclk = ~gclk;   // 250 MHz

   gcff_emul #(.WIDTH(8), .CLK_RISE(1'b1), .ASYNC_MODE(AM_RESET), .CTRL_LOW(1'b0),
               .INIT_VAL(INIT_A), .RST_VAL(RST_A), .SRST_VAL(SRST_A)) u_gcff_emul (
      .gclk(gclk), .rst_n(rst_n), .eclk(eclk_a), .d(d), .ce(ce), .srst(srst),
      .aload(a_aload), .adata(adata), .arst(a_arst), .aset(8'h00), .aclr(8'h00),
      .q(q_a));

   gcff_emul #(.WIDTH(8), .CLK_RISE(1'b0), .ASYNC_MODE(AM_SETCLR), .CTRL_LOW(1'b1),
               .INIT_VAL(INIT_B), .RST_VAL(8'h00), .SRST_VAL(SRST_B)) u_gcff_emul_sc (
      .gclk(gclk), .rst_n(rst_n), .eclk(eclk_b), .d(d), .ce(ce), .srst(srst),
      .aload(b_aload_n), .adata(adata), .arst(1'b1), .aset(b_aset_n), .aclr(b_aclr_n),
      .q(q_b));

   task automatic step();
      @(negedge gclk);
   endtask

   task automatic expect_q(input bit sel_b, input logic [7:0] exp, input string tag);
      sb_item_t it;
      it.exp = exp; it.sel_b = sel_b; it.tag = tag;
      sb.push_back(it);
   endtask

   // monitor: compares one time unit after each falling gclk edge
   initial begin
      forever begin
         @(negedge gclk);
         #1;
         while (sb.size() > 0) begin
            sb_item_t it;
            logic [7:0] act;
            it = sb.pop_front();
            act = it.sel_b ? q_b : q_a;
            checks++;
            if (act !== it.exp) begin
               errors++;
               $display("FAIL %s inst=%s actual=%h expected=%h", it.tag,
                        it.sel_b ? "B" : "A", act, it.exp);
            end
         end
      end
   end

   // one emulated clock cycle on instance A or B, with reference-flop model
   task automatic pulse(input bit on_b, input string tag);
      logic [7:0] nxt;
      nxt = srst ? (on_b ? SRST_B : SRST_A) : (ce ? d : (on_b ? m_b : m_a));
      step();
      if (on_b) begin eclk_b = 1'b0; m_b = nxt; end
      else      begin eclk_a = 1'b1; m_a = nxt; end
      expect_q(on_b, nxt, tag);
      step();
      expect_q(on_b, nxt, tag);
      step();
      if (on_b) eclk_b = 1'b1; else eclk_a = 1'b0;
      expect_q(on_b, nxt, on_b ? "R3" : "R4");
      step();
      expect_q(on_b, nxt, "R4");
   endtask

   initial begin
      repeat (3) step();
      expect_q(1'b0, INIT_A, "R1");
      expect_q(1'b1, INIT_B, "R1");
      step();
      rst_n = 1'b1;
      d = 8'hEE;
      step(); expect_q(1'b0, INIT_A, "R1"); expect_q(1'b1, INIT_B, "R1");
      step(); expect_q(1'b0, INIT_A, "R1"); expect_q(1'b1, INIT_B, "R1");

      // R2 / R3: basic capture on the active transition
      d = 8'h11;
      pulse(1'b0, "R2");
      pulse(1'b1, "R3");

      // R4: data changes with no transition
      d = 8'h22;
      repeat (3) begin step(); expect_q(1'b0, m_a, "R4"); expect_q(1'b1, m_b, "R4"); end

      // R5: enable low reloads the held value
      ce = 1'b0; d = 8'h33;
      pulse(1'b0, "R5");
      pulse(1'b1, "R5");

      // R6: synchronous reset beats the enable
      srst = 1'b1; d = 8'h44;
      pulse(1'b0, "R6");
      pulse(1'b1, "R6");
      srst = 1'b0; ce = 1'b1; d = 8'h66;
      pulse(1'b0, "R2");
      pulse(1'b1, "R3");

      // R3: a rising eclk on the falling-polarity instance is inactive
      d = 8'h99;
      step(); eclk_b = 1'b0; expect_q(1'b1, 8'h99, "R3"); m_b = 8'h99;
      step(); d = 8'h66;
      step(); eclk_b = 1'b1; expect_q(1'b1, 8'h99, "R3");
      step(); expect_q(1'b1, 8'h99, "R3");
      d = 8'h66;
      pulse(1'b1, "R3");

      // R7: asynchronous load, same-cycle effect and widened tail
      step(); adata = 8'h77; a_aload = 1'b1; expect_q(1'b0, 8'h77, "R7");
      step(); expect_q(1'b0, 8'h77, "R7");
      step(); a_aload = 1'b0; adata = 8'h78; expect_q(1'b0, 8'h78, "R7");
      step(); adata = 8'h00; expect_q(1'b0, 8'h78, "R7");
      step(); expect_q(1'b0, 8'h78, "R7");
      m_a = 8'h78;

      // R8: reset overrides a simultaneous load
      step(); a_arst = 1'b1; a_aload = 1'b1; adata = 8'h12; expect_q(1'b0, RST_A, "R8");
      step(); a_arst = 1'b0; a_aload = 1'b0; expect_q(1'b0, RST_A, "R8");
      step(); expect_q(1'b0, RST_A, "R8");
      m_a = RST_A;

      // R8: transition and reset in the same global cycle
      d = 8'h99;
      step();
      step(); eclk_a = 1'b1; a_arst = 1'b1; expect_q(1'b0, RST_A, "R8");
      step(); a_arst = 1'b0; expect_q(1'b0, RST_A, "R8");
      step(); expect_q(1'b0, RST_A, "R8");
      step(); eclk_a = 1'b0; expect_q(1'b0, RST_A, "R8");
      step(); expect_q(1'b0, RST_A, "R8");
      pulse(1'b0, "R2");

      // R9 / R10: active-low set and clear on instance B (m_b = 66)
      step(); expect_q(1'b1, 8'h66, "R10");
      step(); b_aset_n = 8'hF0; expect_q(1'b1, 8'h6F, "R9");
      step(); b_aset_n = 8'hFF; expect_q(1'b1, 8'h6F, "R10");
      step(); expect_q(1'b1, 8'h6F, "R9");
      step(); b_aclr_n = 8'h9F; expect_q(1'b1, 8'h0F, "R9");
      step(); b_aclr_n = 8'hFF;
      step(); expect_q(1'b1, 8'h0F, "R10");
      step(); b_aset_n = 8'hFE; b_aclr_n = 8'hFE; expect_q(1'b1, 8'h0E, "R9");
      step(); b_aset_n = 8'hFF; b_aclr_n = 8'hFF; expect_q(1'b1, 8'h0E, "R9");
      step(); expect_q(1'b1, 8'h0E, "R10");
      m_b = 8'h0E;

      // R10: active-low load on B
      step(); adata = 8'hA5; b_aload_n = 1'b0; expect_q(1'b1, 8'hA5, "R10");
      step(); b_aload_n = 1'b1; expect_q(1'b1, 8'hA5, "R7");
      step(); adata = 8'h00; expect_q(1'b1, 8'hA5, "R10");
      m_b = 8'hA5;
      d = 8'h3C;
      pulse(1'b1, "R3");

      step(); step();
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      #100000;
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule